// File: doc/BRIEF.md
# AFSK tone correlation demodulator

The block turns a stream of signed audio samples into one hard symbol decision per decimated sample. The audio carries two-tone frequency-shift keying at 1200 baud, with a mark tone at 1200 Hz and a space tone at 2200 Hz. The input arrives at 38400 samples per second, which is 32 samples per symbol. The block averages each group of four accepted samples, which leaves eight samples per symbol.

Each decimated sample can first pass through a fixed pre-emphasis equalizer, selected by an input pin, that evens out the levels of the two tones. The sample is then multiplied by cosine and sine references for each tone. Every product is summed over a sliding window one symbol long. The squared magnitudes of the two tones are subtracted, and the difference is scaled and saturated. A first-order filter smooths the difference, and its sign gives the symbol. A second decision is taken from the unfiltered difference and is meant for a carrier-detect loop further downstream.

Top module: `afsk_corr_demod`

## Requirements
- R1: Every four samples accepted with `in_valid` high form one group, and each group produces exactly one decimated value, floor(sum/4). Cycles with `in_valid` low change nothing, whatever `in_sample` holds.
- R2: With `eq_en` high, the decimated value x becomes saturate16(x − floor(p/2)), where p is the previous decimated value. p tracks every decimated value regardless of `eq_en`. With `eq_en` low, x passes through unchanged.
- R3: References come from a 64-entry sine of amplitude 127, rounded to the nearest integer. The cosine is the entry 16 positions ahead. The table index is the top 6 bits of a 16-bit phase that starts at 0 and advances once per decimated sample: by 8192 for mark and by 15019 for space. Each product is floor(y·ref/128).
- R4: For each of the four products, the bench keeps the sum of the last 8 products, counting zeros since reset. The tone energy is I²+Q², and d = saturate24(floor((Emark − Espace)/1024)).
- R5: The filter state f updates once per decimated sample as f ← saturate24(f + floor((d − f)/4)), starting from 0.
- R6: `sym` is 1 when the updated f is greater than 0 (mark) and 0 otherwise. A steady mark tone settles to 1 and a steady space tone settles to 0.
- R7: `raw_sym` is 1 when d is greater than 0, and 0 otherwise.
- R8: `sym_valid` is high for exactly one cycle per group, three clock edges after the edge that accepts the group's fourth sample. `sym` and `raw_sym` change only together with it.
- R9: While `rst` is high at a clock edge, all state is cleared: the partial group, the phases, the previous sample, the windows and the filter. All outputs read 0 afterwards, and later output matches a fresh start.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Qualifies `in_sample` |
| in_sample | input | 16 | Signed audio sample |
| eq_en | input | 1 | Enables the pre-emphasis equalizer |
| sym_valid | output | 1 | One-cycle strobe for each decision |
| sym | output | 1 | Filtered decision, 1 = mark |
| raw_sym | output | 1 | Unfiltered decision for carrier detection |

## Verification
Clean mark and clean space tones show whether the two correlators are told apart and whether the sign convention of the slicer is right. Symbols alternating at random with the equalizer on exercise the window transitions and the equalizer's memory of the previous decimated sample. Uniform noise checks the arithmetic rounding against a bit-exact model, and full-scale square waves drive the difference into saturation. Random gaps carrying junk data test that idle cycles are ignored, and a reset in the middle of a group tests that no partial state survives.

// File: rtl/afsk_pkg.sv
package afsk_pkg;

  localparam int REF_W  = 8;
  localparam int LUT_AW = 6;
  localparam int NCH    = 4;

  function automatic logic signed [63:0] sat_s(input logic signed [63:0] v, input int w);
    logic signed [63:0] hi;
    logic signed [63:0] lo;
    hi = (64'sd1 <<< (w - 1)) - 64'sd1;
    lo = -hi - 64'sd1;
    if (v > hi) return hi;
    if (v < lo) return lo;
    return v;
  endfunction

  function automatic logic signed [REF_W-1:0] quarter_wave(input logic [4:0] k);
    case (k)
      5'd0:  return 8'sd0;
      5'd1:  return 8'sd12;
      5'd2:  return 8'sd25;
      5'd3:  return 8'sd37;
      5'd4:  return 8'sd49;
      5'd5:  return 8'sd60;
      5'd6:  return 8'sd71;
      5'd7:  return 8'sd81;
      5'd8:  return 8'sd90;
      5'd9:  return 8'sd98;
      5'd10: return 8'sd106;
      5'd11: return 8'sd112;
      5'd12: return 8'sd117;
      5'd13: return 8'sd122;
      5'd14: return 8'sd125;
      5'd15: return 8'sd126;
      5'd16: return 8'sd127;
      default: return 8'sd0;
    endcase
  endfunction

  function automatic logic signed [REF_W-1:0] sine_lut(input logic [LUT_AW-1:0] idx);
    logic [4:0] k;
    logic signed [REF_W-1:0] mag;
    k   = idx[4] ? (5'd16 - {1'b0, idx[3:0]}) : {1'b0, idx[3:0]};
    mag = quarter_wave(k);
    return idx[5] ? -mag : mag;
  endfunction

  function automatic logic signed [REF_W-1:0] cos_lut(input logic [LUT_AW-1:0] idx);
    return sine_lut(LUT_AW'(idx + 6'd16));
  endfunction

endpackage

// File: rtl/afsk_decim.sv
module afsk_decim #(
  parameter int SW    = 16,
  parameter int DECIM = 4
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 in_valid,
  input  logic signed [SW-1:0] in_sample,
  output logic                 grp_done,
  output logic                 dec_valid,
  output logic signed [SW-1:0] dec_sample
);
  localparam int CW = $clog2(DECIM);
  localparam int AW = SW + CW;

  logic [CW-1:0]         cnt;
  logic signed [AW-1:0]  acc;
  logic signed [AW-1:0]  acc_next;

  assign grp_done = in_valid && (cnt == CW'(DECIM - 1));
  assign acc_next = acc + AW'(in_sample);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt        <= '0;
      acc        <= '0;
      dec_valid  <= 1'b0;
      dec_sample <= '0;
    end else begin
      dec_valid <= grp_done;
      if (in_valid) begin
        if (grp_done) begin
          cnt        <= '0;
          acc        <= '0;
          dec_sample <= SW'(acc_next >>> CW);
        end else begin
          cnt <= cnt + 1'b1;
          acc <= acc_next;
        end
      end
    end
  end
endmodule

// File: rtl/afsk_mixer.sv
module afsk_mixer
  import afsk_pkg::*;
#(
  parameter int SW         = 16,
  parameter int PW         = 16,
  parameter int MARK_STEP  = 8192,
  parameter int SPACE_STEP = 15019
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      dec_valid,
  input  logic signed [SW-1:0]      dec_sample,
  input  logic                      eq_en,
  output logic signed [SW-1:0]      eq_sample,
  output logic                      mix_valid,
  output logic [NCH-1:0][SW-1:0]    mix_q
);
  localparam int PRW = SW + REF_W;

  logic signed [SW-1:0]    prev;
  logic [PW-1:0]           ph_mark;
  logic [PW-1:0]           ph_space;
  logic signed [REF_W-1:0] refs [NCH];
  logic signed [PRW-1:0]   prod [NCH];

  always_comb begin
    if (eq_en)
      eq_sample = SW'(sat_s(64'(dec_sample) - (64'(prev) >>> 1), SW));
    else
      eq_sample = dec_sample;
    refs[0] = cos_lut(ph_mark[PW-1 -: LUT_AW]);
    refs[1] = sine_lut(ph_mark[PW-1 -: LUT_AW]);
    refs[2] = cos_lut(ph_space[PW-1 -: LUT_AW]);
    refs[3] = sine_lut(ph_space[PW-1 -: LUT_AW]);
  end

  for (genvar c = 0; c < NCH; c++) begin : g_mul
    assign prod[c] = PRW'(eq_sample) * PRW'(refs[c]);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      prev      <= '0;
      ph_mark   <= '0;
      ph_space  <= '0;
      mix_valid <= 1'b0;
      mix_q     <= '0;
    end else begin
      mix_valid <= dec_valid;
      if (dec_valid) begin
        prev     <= dec_sample;
        ph_mark  <= ph_mark + PW'(MARK_STEP);
        ph_space <= ph_space + PW'(SPACE_STEP);
        for (int c = 0; c < NCH; c++) mix_q[c] <= SW'(prod[c] >>> (REF_W - 1));
      end
    end
  end
endmodule

// File: rtl/afsk_window.sv
module afsk_window
  import afsk_pkg::*;
#(
  parameter  int SW   = 16,
  parameter  int WIN  = 8,
  localparam int SUMW = SW + $clog2(WIN)
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     mix_valid,
  input  logic [NCH-1:0][SW-1:0]   mix_q,
  output logic                     win_valid,
  output logic [NCH-1:0][SUMW-1:0] sums
);
  always_ff @(posedge clk) begin
    if (rst) win_valid <= 1'b0;
    else     win_valid <= mix_valid;
  end

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic signed [SW-1:0]   taps [WIN];
    logic signed [SUMW-1:0] acc;
    logic signed [SW-1:0]   nw;

    assign nw      = $signed(mix_q[c]);
    assign sums[c] = acc;

    always_ff @(posedge clk) begin
      if (rst) begin
        acc <= '0;
        for (int i = 0; i < WIN; i++) taps[i] <= '0;
      end else if (mix_valid) begin
        acc     <= acc + SUMW'(nw) - SUMW'(taps[WIN-1]);
        taps[0] <= nw;
        for (int i = 1; i < WIN; i++) taps[i] <= taps[i-1];
      end
    end
  end
endmodule

// File: rtl/afsk_corr_demod.sv
module afsk_corr_demod
  import afsk_pkg::*;
#(
  parameter int SAMPLE_W   = 16,
  parameter int FS_HZ      = 38400,
  parameter int DECIM      = 4,
  parameter int MARK_HZ    = 1200,
  parameter int SPACE_HZ   = 2200,
  parameter int PHASE_W    = 16,
  parameter int WIN        = 8,
  parameter int DIFF_SHIFT = 10,
  parameter int LPF_W      = 24,
  parameter int LPF_SHIFT  = 2
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       in_valid,
  input  logic signed [SAMPLE_W-1:0] in_sample,
  input  logic                       eq_en,
  output logic                       sym_valid,
  output logic                       sym,
  output logic                       raw_sym
);
  localparam int DEC_HZ     = FS_HZ / DECIM;
  localparam int MARK_STEP  = (MARK_HZ * (1 << PHASE_W) + DEC_HZ / 2) / DEC_HZ;
  localparam int SPACE_STEP = (SPACE_HZ * (1 << PHASE_W) + DEC_HZ / 2) / DEC_HZ;
  localparam int SUMW       = SAMPLE_W + $clog2(WIN);
  localparam int EW         = 2 * SUMW + 1;
  localparam int DW         = EW + 1;

  logic                         grp_done;
  logic                         dec_valid;
  logic signed [SAMPLE_W-1:0]   dec_sample;
  logic signed [SAMPLE_W-1:0]   eq_sample;
  logic                         mix_valid;
  logic [NCH-1:0][SAMPLE_W-1:0] mix_q;
  logic                         win_valid;
  logic [NCH-1:0][SUMW-1:0]     sums;

  logic signed [SUMW-1:0]  m_i, m_q, s_i, s_q;
  logic signed [EW-1:0]    e_mark, e_space;
  logic signed [DW-1:0]    e_diff;
  logic signed [LPF_W-1:0] d_sat;
  logic signed [LPF_W-1:0] lpf;
  logic signed [LPF_W-1:0] lpf_next;

  afsk_decim #(.SW(SAMPLE_W), .DECIM(DECIM)) u_decim (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_sample(in_sample),
    .grp_done(grp_done), .dec_valid(dec_valid), .dec_sample(dec_sample)
  );

  afsk_mixer #(.SW(SAMPLE_W), .PW(PHASE_W), .MARK_STEP(MARK_STEP), .SPACE_STEP(SPACE_STEP)) u_mixer (
    .clk(clk), .rst(rst), .dec_valid(dec_valid), .dec_sample(dec_sample), .eq_en(eq_en),
    .eq_sample(eq_sample), .mix_valid(mix_valid), .mix_q(mix_q)
  );

  afsk_window #(.SW(SAMPLE_W), .WIN(WIN)) u_window (
    .clk(clk), .rst(rst), .mix_valid(mix_valid), .mix_q(mix_q),
    .win_valid(win_valid), .sums(sums)
  );

  always_comb begin
    m_i      = $signed(sums[0]);
    m_q      = $signed(sums[1]);
    s_i      = $signed(sums[2]);
    s_q      = $signed(sums[3]);
    e_mark   = EW'(m_i) * EW'(m_i) + EW'(m_q) * EW'(m_q);
    e_space  = EW'(s_i) * EW'(s_i) + EW'(s_q) * EW'(s_q);
    e_diff   = DW'(e_mark) - DW'(e_space);
    d_sat    = LPF_W'(sat_s(64'(e_diff >>> DIFF_SHIFT), LPF_W));
    lpf_next = LPF_W'(sat_s(64'(lpf) + ((64'(d_sat) - 64'(lpf)) >>> LPF_SHIFT), LPF_W));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      lpf       <= '0;
      sym_valid <= 1'b0;
      sym       <= 1'b0;
      raw_sym   <= 1'b0;
    end else begin
      sym_valid <= win_valid;
      if (win_valid) begin
        lpf     <= lpf_next;
        sym     <= (lpf_next > 0);
        raw_sym <= (d_sat > 0);
      end
    end
  end
endmodule

// File: rtl/afsk_corr_demod_chk.sv
module afsk_corr_demod_chk (
  input logic clk,
  input logic rst,
  input logic grp_done,
  input logic dec_valid,
  input logic win_valid,
  input logic sym_valid,
  input logic sym,
  input logic raw_sym
);
  logic [2:0] since_rst;
  logic       seen_rst;

  always_ff @(posedge clk) begin
    if (rst) begin
      since_rst <= '0;
      seen_rst  <= 1'b1;
    end else if (since_rst != 3'd7) begin
      since_rst <= since_rst + 3'd1;
    end
  end

  // R8: strobe follows the accepting edge of a group's last sample by a fixed distance
  a_r8_latency: assert property (@(posedge clk) disable iff (rst)
    (since_rst >= 3'd4) |-> (sym_valid == $past(grp_done, 4)));

  // R8: strobe lasts one cycle
  a_r8_single_pulse: assert property (@(posedge clk) disable iff (rst)
    sym_valid |=> !sym_valid);

  // R1: a completed group yields one decimated value on the next cycle, never two in a row
  a_r1_group_to_dec: assert property (@(posedge clk) disable iff (rst)
    grp_done |=> dec_valid);
  a_r1_dec_spacing: assert property (@(posedge clk) disable iff (rst)
    dec_valid |=> !dec_valid);

  // R6 / R7: decisions move only when a new decision is produced
  a_r6_decision_hold: assert property (@(posedge clk) disable iff (rst)
    !win_valid |=> ($stable(sym) && $stable(raw_sym)));

  // R9: after a reset edge all outputs read zero
  a_r9_reset_clear: assert property (@(posedge clk)
    (seen_rst && $past(rst)) |-> (!sym_valid && !sym && !raw_sym));
endmodule

bind afsk_corr_demod afsk_corr_demod_chk u_chk (
  .clk(clk), .rst(rst), .grp_done(grp_done), .dec_valid(dec_valid),
  .win_valid(win_valid), .sym_valid(sym_valid), .sym(sym), .raw_sym(raw_sym)
);

// File: tb/afsk_corr_demod_tb.sv
module afsk_corr_demod_tb;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0;
  logic eq_en = 1'b0;
  logic signed [15:0] in_sample = '0;
  logic sym_valid, sym, raw_sym;

  always #10 clk = ~clk;

  afsk_corr_demod u_dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_sample(in_sample),
    .eq_en(eq_en), .sym_valid(sym_valid), .sym(sym), .raw_sym(raw_sym)
  );

  int checks = 0;
  int errors = 0;
  longint cyc = 0;
  longint n_in = 0;
  string cur_tag = "R9";
  bit last_sym = 0;
  bit last_raw = 0;

  // bench model state
  int     m_cnt;
  longint m_acc, m_prev, m_lpf, m_n;
  longint win [4][8];
  bit     q_sym [$];
  bit     q_raw [$];
  longint q_cyc [$];

  always @(posedge clk) cyc <= cyc + 1;

  function automatic longint fdiv(longint a, longint b);
    longint q;
    q = a / b;
    if ((a % b != 0) && (a < 0)) q = q - 1;
    return q;
  endfunction

  function automatic longint satw(longint v, int w);
    longint hi;
    hi = (longint'(1) <<< (w - 1)) - 1;
    if (v > hi) return hi;
    if (v < -hi - 1) return -hi - 1;
    return v;
  endfunction

  function automatic longint ref_val(longint idx);
    real v;
    v = 127.0 * $sin(2.0 * 3.14159265358979 * real'(idx % 64) / 64.0);
    if (v >= 0.0) return longint'($rtoi(v + 0.5));
    return -longint'($rtoi(-v + 0.5));
  endfunction

  task automatic model_reset();
    m_cnt = 0; m_acc = 0; m_prev = 0; m_lpf = 0; m_n = 0;
    for (int c = 0; c < 4; c++) for (int k = 0; k < 8; k++) win[c][k] = 0;
    q_sym.delete(); q_raw.delete(); q_cyc.delete();
  endtask

  task automatic model_dec(longint x, longint acc_cyc);
    longint y, mi, si, em, es, d;
    longint p [4];
    longint s [4];
    y = eq_en ? satw(x - fdiv(m_prev, 2), 16) : x;
    m_prev = x;
    mi = ((m_n * 8192) % 65536) / 1024;
    si = ((m_n * 15019) % 65536) / 1024;
    p[0] = fdiv(y * ref_val(mi + 16), 128);
    p[1] = fdiv(y * ref_val(mi), 128);
    p[2] = fdiv(y * ref_val(si + 16), 128);
    p[3] = fdiv(y * ref_val(si), 128);
    for (int c = 0; c < 4; c++) begin
      for (int k = 7; k > 0; k--) win[c][k] = win[c][k-1];
      win[c][0] = p[c];
      s[c] = 0;
      for (int k = 0; k < 8; k++) s[c] += win[c][k];
    end
    em = s[0] * s[0] + s[1] * s[1];
    es = s[2] * s[2] + s[3] * s[3];
    d = satw(fdiv(em - es, 1024), 24);
    m_lpf = satw(m_lpf + fdiv(d - m_lpf, 4), 24);
    q_sym.push_back(m_lpf > 0);
    q_raw.push_back(d > 0);
    q_cyc.push_back(acc_cyc + 3);
    m_n++;
  endtask

  task automatic check(bit ok, string req, longint act, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d (t=%0t)", req, act, exp, $time);
    end
  endtask

  task automatic feed(logic signed [15:0] s);
    int gap;
    gap = $urandom_range(0, 2);
    repeat (gap) begin
      @(negedge clk);
      in_valid  = 1'b0;
      in_sample = 16'($urandom);   // junk on idle cycles (R1)
    end
    @(negedge clk);
    in_valid  = 1'b1;
    in_sample = s;
    n_in++;
    m_acc += longint'(s);
    m_cnt++;
    if (m_cnt == 4) begin
      model_dec(fdiv(m_acc, 4), cyc + 1);
      m_acc = 0;
      m_cnt = 0;
    end
  endtask

  task automatic drain(string req);
    @(negedge clk);
    in_valid = 1'b0;
    repeat (8) @(negedge clk);
    check(q_sym.size() == 0, req, q_sym.size(), 0);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    in_valid = 1'b0;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    model_reset();
  endtask

  function automatic logic signed [15:0] tone(real f, real amp);
    return 16'($rtoi(amp * $sin(2.0 * 3.14159265358979 * f * real'(n_in) / 38400.0)));
  endfunction

  // output monitor
  always @(negedge clk) begin
    if (!rst && sym_valid) begin
      if (q_sym.size() == 0) begin
        check(1'b0, "R8 unexpected strobe", 1, 0);
      end else begin
        check(cyc == q_cyc[0], "R8 strobe cycle", cyc, q_cyc[0]);
        check(sym == q_sym[0], {cur_tag, " R5 R6 sym"}, sym, q_sym[0]);
        check(raw_sym == q_raw[0], {cur_tag, " R4 R7 raw_sym"}, raw_sym, q_raw[0]);
        void'(q_sym.pop_front()); void'(q_raw.pop_front()); void'(q_cyc.pop_front());
        last_sym = sym;
        last_raw = raw_sym;
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    check(1'b0, "R8 watchdog expired", 0, 1);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    model_reset();
    do_reset();
    @(negedge clk);
    check(sym_valid == 1'b0, "R9 reset sym_valid", sym_valid, 0);
    check(sym == 1'b0, "R9 reset sym", sym, 0);
    check(raw_sym == 1'b0, "R9 reset raw_sym", raw_sym, 0);

    // clean mark tone
    cur_tag = "R3 mark";
    eq_en = 1'b0;
    for (int i = 0; i < 256; i++) feed(tone(1200.0, 12000.0));
    drain("R1 mark count");
    check(last_sym == 1'b1, "R6 mark settles to 1", last_sym, 1);

    // clean space tone
    cur_tag = "R3 space";
    for (int i = 0; i < 256; i++) feed(tone(2200.0, 12000.0));
    drain("R1 space count");
    check(last_sym == 1'b0, "R6 space settles to 0", last_sym, 0);

    // random symbols with equalizer on
    cur_tag = "R2 eq symbols";
    eq_en = 1'b1;
    for (int b = 0; b < 20; b++) begin
      bit mk;
      mk = 1'($urandom);
      for (int i = 0; i < 32; i++) feed(tone(mk ? 1200.0 : 2200.0, 10000.0));
    end
    drain("R1 eq count");

    // noise, both equalizer settings
    cur_tag = "R4 noise";
    eq_en = 1'b0;
    for (int i = 0; i < 512; i++) feed(16'($urandom));
    drain("R1 noise count");
    cur_tag = "R2 noise eq";
    eq_en = 1'b1;
    for (int i = 0; i < 256; i++) feed(16'($urandom));
    drain("R1 noise eq count");

    // full-scale square waves: saturation of the difference and the equalizer
    cur_tag = "R4 full scale";
    eq_en = 1'b0;
    for (int i = 0; i < 256; i++) feed((tone(1200.0, 1000.0) >= 0) ? 16'sd32767 : -16'sd32768);
    for (int i = 0; i < 256; i++) feed((tone(2200.0, 1000.0) >= 0) ? 16'sd32767 : -16'sd32768);
    drain("R1 full scale count");
    cur_tag = "R2 full scale eq";
    eq_en = 1'b1;
    for (int i = 0; i < 256; i++) feed((tone(1200.0, 1000.0) >= 0) ? 16'sd32767 : -16'sd32768);
    drain("R1 full scale eq count");
    check(last_sym == 1'b1, "R6 full-scale mark", last_sym, 1);

    // reset in the middle of a group after a mark run
    cur_tag = "R9 pre-reset";
    eq_en = 1'b0;
    for (int i = 0; i < 128; i++) feed(tone(1200.0, 12000.0));
    drain("R1 pre-reset count");
    feed(16'sd20000);
    feed(16'sd20000);
    do_reset();
    @(negedge clk);
    check(sym == 1'b0, "R9 mid-group reset sym", sym, 0);
    check(raw_sym == 1'b0, "R9 mid-group reset raw_sym", raw_sym, 0);
    check(sym_valid == 1'b0, "R9 mid-group reset sym_valid", sym_valid, 0);

    cur_tag = "R9 fresh start";
    n_in = 0;
    for (int i = 0; i < 128; i++) feed(tone(1200.0, 12000.0));
    drain("R1 fresh start count");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule